// File: doc/BRIEF.md
# ADC Result Readout over a Two-Wire Serial Bus

This block is the serial-bus target side of a single-channel 12-bit converter. It runs from a fast system clock and sees the bus lines only after they pass through synchronisers. From the synchronised lines it detects START and STOP conditions and SCL edges. It then takes in an address byte and compares the top seven bits with a fixed device code of `1001` followed by three strap bits.

A read address makes the block acknowledge, request a conversion and return the result as two bytes. The high byte is zero-padded and the low byte carries the lower eight result bits. While the controller keeps acknowledging, the block streams one fresh sample per two bytes, and no new address is sent. A write address is acknowledged only, so that a controller can check that the device is present. SDA is driven through an active-high pull-low enable, and the block never drives the line high.

The converter itself is outside the block. The block gives a one-cycle `conv_start` pulse, and the converter must present its result on `conv_result` before the falling SCL edge at which the block takes it in.

Top module: `i2c_adc_readout`

## Requirements
- R1: After reset, `sda_oe` and `conv_start` are low and the bus lines are left released.
- R2: START is an SDA fall while SCL is high, and STOP is an SDA rise while SCL is high. A STOP returns the block to idle with SDA released. A START in any state, including one in the middle of a data byte, abandons the transfer and begins a new address reception.
- R3: An address byte whose first seven bits, MSB first, equal `1001` followed by `addr_strap[2:0]` is acknowledged: SDA is held low through the 9th SCL clock. Any other address gets no acknowledge, and SDA stays released until the next START.
- R4: A matching address with its 8th bit at 0 (write) is acknowledged but starts no conversion. After the acknowledge, SDA stays released until a STOP or a repeated START, and both of these are accepted.
- R5: A matching address with its 8th bit at 1 (read) gives exactly one single-cycle `conv_start` pulse. The pulse follows the SCL fall that ends that bit, while SCL is low.
- R6: After a read acknowledge, the block sends two bytes MSB first. The first is four 0 bits followed by result bits 11..8, and the second is result bits 7..0. `conv_result` is taken in at the SCL fall that ends the address acknowledge. SDA changes only while SCL is low.
- R7: At the SCL fall that ends the last bit of each low byte, `conv_start` pulses once. If the controller acknowledges that byte (SDA low on the 9th clock), another high/low byte pair follows without a new address. That pair carries `conv_result` as sampled at the fall that ends this acknowledge.
- R8: If the controller does not acknowledge a byte (SDA high on the 9th clock), the block releases SDA. It sends nothing more (the line reads all ones) until a START.
- R9: Changing `addr_strap` changes the matched address, so the old strap value is no longer acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16 times the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as received |
| sda_i | input | 1 | Bus data line as received |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| addr_strap | input | 3 | Low three bits of the device address |
| conv_start | output | 1 | One-cycle request to start a conversion |
| conv_result | input | 12 | Converted sample, straight binary |

## Verification
The assertions assume that the bus controller is legal. It changes SDA only while SCL is low, except for START and STOP. It never makes a START or STOP while the block is pulling SDA low. Each SCL level lasts many system clocks, so no edge is lost through the synchronisers.

The bench's bus model drives each SCL quarter period for ten system clocks and changes SDA only in the low phase. It issues START or STOP only at points where the block has released the line. It samples SDA in the middle of the high phase, well after the block's delayed output has settled.

// File: rtl/i2cr_pkg.sv
package i2cr_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,      // bus free or not addressed
        ST_ADDR,      // shifting in the address byte
        ST_ADDR_ACK,  // driving acknowledge for our address
        ST_TX,        // shifting out a result byte
        ST_TX_ACK,    // sampling the controller's acknowledge
        ST_WAIT       // released, waiting for START or STOP
    } xfer_st_e;
endpackage

// File: rtl/i2cr_line_sync.sv
module i2cr_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_raw,
    input  logic sda_raw,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    typedef struct packed {
        logic [STAGES-1:0] scl_sh;
        logic [STAGES-1:0] sda_sh;
        logic              scl_p;
        logic              sda_p;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d        = sync_q;
        sync_d.scl_sh = {sync_q.scl_sh[STAGES-2:0], scl_raw};
        sync_d.sda_sh = {sync_q.sda_sh[STAGES-2:0], sda_raw};
        sync_d.scl_p  = sync_q.scl_sh[STAGES-1];
        sync_d.sda_p  = sync_q.sda_sh[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;   // idle bus reads high
        else        sync_q <= sync_d;
    end

    assign scl_s     = sync_q.scl_sh[STAGES-1];
    assign sda_s     = sync_q.sda_sh[STAGES-1];
    assign scl_rise  =  scl_s & ~sync_q.scl_p;
    assign scl_fall  = ~scl_s &  sync_q.scl_p;
    assign start_det =  scl_s &  sync_q.scl_p &  sync_q.sda_p & ~sda_s;
    assign stop_det  =  scl_s &  sync_q.scl_p & ~sync_q.sda_p &  sda_s;
endmodule

// File: rtl/i2cr_xfer_fsm.sv
module i2cr_xfer_fsm
    import i2cr_pkg::*;
#(
    parameter logic [3:0] DEV_CODE = 4'b1001,
    parameter int         DATA_W   = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [2:0]        addr_strap,
    input  logic [DATA_W-1:0] conv_result,
    output logic              sda_oe,
    output logic              conv_start
);
    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W + 1);
    localparam int HI_W   = DATA_W - BYTE_W;
    localparam int PAD_W  = BYTE_W - HI_W;       // DATA_W must be 9..15
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BYTE_W);

    typedef struct packed {
        xfer_st_e          st;
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] sr;      // address in / data out shifter
        logic [BYTE_W-1:0] lo;      // low byte held for the second beat
        logic              rw;
        logic              lo_sel;  // 1 while the low byte is on the wire
        logic              ack_ok;
        logic              oe;
        logic              conv;
    } fsm_t;

    fsm_t fsm_d, fsm_q;
    logic [BYTE_W-1:0] hi_byte;

    assign hi_byte = {{PAD_W{1'b0}}, conv_result[DATA_W-1:BYTE_W]};

    always_comb begin
        fsm_d      = fsm_q;
        fsm_d.conv = 1'b0;
        if (stop_det) begin
            fsm_d.st = ST_IDLE;
            fsm_d.oe = 1'b0;
        end else if (start_det) begin
            fsm_d.st  = ST_ADDR;
            fsm_d.cnt = '0;
            fsm_d.oe  = 1'b0;
        end else begin
            unique case (fsm_q.st)
                ST_ADDR: begin
                    if (scl_rise) begin
                        fsm_d.sr  = {fsm_q.sr[BYTE_W-2:0], sda_s};
                        fsm_d.cnt = fsm_q.cnt + 1'b1;
                    end else if (scl_fall && fsm_q.cnt == FULL_CNT) begin
                        fsm_d.rw = fsm_q.sr[0];
                        if (fsm_q.sr[BYTE_W-1:1] == {DEV_CODE, addr_strap}) begin
                            fsm_d.st   = ST_ADDR_ACK;
                            fsm_d.oe   = 1'b1;
                            fsm_d.conv = fsm_q.sr[0];
                        end else begin
                            fsm_d.st = ST_WAIT;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        if (fsm_q.rw) begin
                            fsm_d.sr     = hi_byte;
                            fsm_d.lo     = conv_result[BYTE_W-1:0];
                            fsm_d.oe     = ~hi_byte[BYTE_W-1];
                            fsm_d.lo_sel = 1'b0;
                            fsm_d.cnt    = '0;
                            fsm_d.st     = ST_TX;
                        end else begin
                            fsm_d.oe = 1'b0;
                            fsm_d.st = ST_WAIT;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (fsm_q.cnt == LAST_BIT) begin
                            fsm_d.oe     = 1'b0;
                            fsm_d.cnt    = '0;
                            fsm_d.ack_ok = 1'b0;
                            fsm_d.conv   = fsm_q.lo_sel;
                            fsm_d.st     = ST_TX_ACK;
                        end else begin
                            fsm_d.cnt = fsm_q.cnt + 1'b1;
                            fsm_d.sr  = {fsm_q.sr[BYTE_W-2:0], 1'b0};
                            fsm_d.oe  = ~fsm_q.sr[BYTE_W-2];
                        end
                    end
                end
                ST_TX_ACK: begin
                    if (scl_rise) begin
                        fsm_d.ack_ok = ~sda_s;
                    end else if (scl_fall) begin
                        if (!fsm_q.ack_ok) begin
                            fsm_d.oe = 1'b0;
                            fsm_d.st = ST_WAIT;
                        end else if (!fsm_q.lo_sel) begin
                            fsm_d.sr     = fsm_q.lo;
                            fsm_d.oe     = ~fsm_q.lo[BYTE_W-1];
                            fsm_d.lo_sel = 1'b1;
                            fsm_d.st     = ST_TX;
                        end else begin
                            fsm_d.sr     = hi_byte;
                            fsm_d.lo     = conv_result[BYTE_W-1:0];
                            fsm_d.oe     = ~hi_byte[BYTE_W-1];
                            fsm_d.lo_sel = 1'b0;
                            fsm_d.st     = ST_TX;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q    <= '0;
            fsm_q.st <= ST_IDLE;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign sda_oe     = fsm_q.oe;
    assign conv_start = fsm_q.conv;

    // R2: STOP leaves the block idle with the line released
    a_r2_stop_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (fsm_q.st == ST_IDLE && !sda_oe));
    // R2: START always restarts address reception
    a_r2_start_to_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det && !stop_det) |=> (fsm_q.st == ST_ADDR));
    // R6: the driven level moves only while SCL is low
    a_r6_oe_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_s);
    // R5: a conversion request follows a detected SCL fall
    a_r5_conv_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> $past(scl_fall));
    // R5: the request lasts one cycle
    a_r5_conv_single: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);
    // R8: released whenever not part of a transfer
    a_r8_release_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.st == ST_WAIT || fsm_q.st == ST_IDLE) |-> !sda_oe);
endmodule

// File: rtl/i2c_adc_readout.sv
module i2c_adc_readout #(
    parameter logic [3:0] DEV_CODE    = 4'b1001,
    parameter int         DATA_W      = 12,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic [2:0]        addr_strap,
    output logic              conv_start,
    input  logic [DATA_W-1:0] conv_result
);
    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

    i2cr_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_raw   (scl_i),
        .sda_raw   (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2cr_xfer_fsm #(.DEV_CODE(DEV_CODE), .DATA_W(DATA_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_s       (scl_s),
        .sda_s       (sda_s),
        .scl_rise    (scl_rise),
        .scl_fall    (scl_fall),
        .start_det   (start_det),
        .stop_det    (stop_det),
        .addr_strap  (addr_strap),
        .conv_result (conv_result),
        .sda_oe      (sda_oe),
        .conv_start  (conv_start)
    );
endmodule

// File: tb/tb_i2c_adc_readout.sv
module tb_i2c_adc_readout;
    localparam int Q = 10;   // system clocks per SCL quarter period

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m_scl = 1'b1;
    logic        m_sda_low = 1'b0;
    logic        sda_line;
    logic        sda_oe, conv_start;
    logic [2:0]  addr_strap = 3'b101;
    logic [11:0] conv_result = '0;

    int checks = 0;
    int errors = 0;
    int conv_cnt = 0;
    int conv_hi_scl = 0;
    int oe_hi_scl = 0;
    logic oe_prev = 1'b0;

    always #2 clk = ~clk;

    assign sda_line = ~(m_sda_low | sda_oe);

    i2c_adc_readout dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (m_scl),
        .sda_i       (sda_line),
        .sda_oe      (sda_oe),
        .addr_strap  (addr_strap),
        .conv_start  (conv_start),
        .conv_result (conv_result)
    );

    always @(posedge clk) begin
        if (conv_start) begin
            conv_cnt <= conv_cnt + 1;
            if (m_scl) conv_hi_scl <= conv_hi_scl + 1;
        end
        if (sda_oe !== oe_prev && m_scl) oe_hi_scl <= oe_hi_scl + 1;
        oe_prev <= sda_oe;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic qw();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda_low = 1'b0; qw();
        m_scl = 1'b1;     qw();
        m_sda_low = 1'b1; qw();
        m_scl = 1'b0;     qw();
    endtask

    task automatic bus_stop();
        m_sda_low = 1'b1; qw();
        m_scl = 1'b1;     qw();
        m_sda_low = 1'b0; qw(); qw();
    endtask

    task automatic clk_bit(input logic b, output logic r);
        m_sda_low = ~b; qw();
        m_scl = 1'b1;   qw();
        r = sda_line;   qw();
        m_scl = 1'b0;   qw();
    endtask

    task automatic send_byte(input logic [7:0] v, output logic acked);
        logic r;
        for (int i = 7; i >= 0; i--) clk_bit(v[i], r);
        clk_bit(1'b1, r);
        acked = ~r;
    endtask

    // nxt is presented on conv_result before the acknowledge clock
    task automatic read_byte(input logic m_ack, input logic [11:0] nxt, output logic [7:0] v);
        logic r;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, r);
            v[i] = r;
        end
        conv_result = nxt;
        clk_bit(~m_ack, r);
    endtask

    task automatic t_reset();
        chk("R1 sda_oe after reset", int'(sda_oe), 0);
        chk("R1 conv_start after reset", int'(conv_start), 0);
        chk("R1 bus released", int'(sda_line), 1);
    endtask

    task automatic t_single_read(input logic [11:0] val);
        logic a; logic [7:0] b; int c0;
        conv_result = val;
        c0 = conv_cnt;
        bus_start();
        send_byte({4'b1001, 3'b101, 1'b1}, a);
        chk("R3 read address ack", int'(a), 1);
        chk("R5 one conversion after address", conv_cnt - c0, 1);
        read_byte(1'b1, val, b);
        chk("R6 high byte", int'(b), int'({4'h0, val[11:8]}));
        read_byte(1'b0, val, b);
        chk("R6 low byte", int'(b), int'(val[7:0]));
        chk("R7 conversion at low byte LSB", conv_cnt - c0, 2);
        read_byte(1'b0, val, b);
        chk("R8 released after NAK", int'(b), 8'hFF);
        bus_stop();
        chk("R2 released after STOP", int'(sda_oe), 0);
    endtask

    task automatic t_stream();
        logic a; logic [7:0] b; int c0;
        logic [11:0] vals [3];
        vals[0] = 12'h123; vals[1] = 12'hFED; vals[2] = 12'h801;
        conv_result = vals[0];
        c0 = conv_cnt;
        bus_start();
        send_byte({4'b1001, 3'b101, 1'b1}, a);
        chk("R3 stream address ack", int'(a), 1);
        for (int k = 0; k < 3; k++) begin
            read_byte(1'b1, vals[k], b);
            chk("R7 streamed high byte", int'(b), int'({4'h0, vals[k][11:8]}));
            read_byte(k < 2, (k < 2) ? vals[k+1] : vals[k], b);
            chk("R7 streamed low byte", int'(b), int'(vals[k][7:0]));
        end
        chk("R7 conversions in stream", conv_cnt - c0, 4);
        bus_stop();
    endtask

    task automatic t_write_poll();
        logic a; logic [7:0] b; int c0;
        c0 = conv_cnt;
        bus_start();
        send_byte({4'b1001, 3'b101, 1'b0}, a);
        chk("R4 write address ack", int'(a), 1);
        chk("R4 no conversion on write", conv_cnt - c0, 0);
        read_byte(1'b0, conv_result, b);
        chk("R4 released after write ack", int'(b), 8'hFF);
        conv_result = 12'h3C7;
        bus_start();
        send_byte({4'b1001, 3'b101, 1'b1}, a);
        chk("R4 repeated START accepted", int'(a), 1);
        read_byte(1'b1, 12'h3C7, b);
        chk("R4 data after repeated START", int'(b), 8'h03);
        read_byte(1'b0, 12'h3C7, b);
        chk("R4 low byte after repeated START", int'(b), 8'hC7);
        bus_stop();
    endtask

    task automatic t_mismatch();
        logic a; logic [7:0] b; int c0;
        c0 = conv_cnt;
        bus_start();
        send_byte({4'b1000, 3'b101, 1'b1}, a);
        chk("R3 wrong device code not acked", int'(a), 0);
        read_byte(1'b1, conv_result, b);
        chk("R3 silent after mismatch", int'(b), 8'hFF);
        chk("R3 no conversion on mismatch", conv_cnt - c0, 0);
        bus_stop();
    endtask

    task automatic t_strap();
        logic a; logic [7:0] b;
        addr_strap = 3'b010;
        conv_result = 12'h6B4;
        bus_start();
        send_byte({4'b1001, 3'b101, 1'b1}, a);
        chk("R9 old strap not acked", int'(a), 0);
        bus_stop();
        bus_start();
        send_byte({4'b1001, 3'b010, 1'b1}, a);
        chk("R9 new strap acked", int'(a), 1);
        read_byte(1'b1, 12'h6B4, b);
        chk("R9 data with new strap", int'(b), 8'h06);
        read_byte(1'b0, 12'h6B4, b);
        bus_stop();
        addr_strap = 3'b101;
    endtask

    task automatic t_abort();
        logic a, r; logic [7:0] b;
        conv_result = 12'hFFF;
        bus_start();
        send_byte({4'b1001, 3'b101, 1'b1}, a);
        read_byte(1'b1, 12'hFFF, b);
        chk("R6 full-scale high byte", int'(b), 8'h0F);
        for (int i = 0; i < 3; i++) clk_bit(1'b1, r);
        conv_result = 12'h456;
        bus_start();   // abandon mid low byte
        send_byte({4'b1001, 3'b101, 1'b1}, a);
        chk("R2 START mid byte restarts", int'(a), 1);
        read_byte(1'b1, 12'h456, b);
        chk("R2 high byte after abort", int'(b), 8'h04);
        read_byte(1'b0, 12'h456, b);
        chk("R2 low byte after abort", int'(b), 8'h56);
        bus_stop();
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_single_read(12'hA5C);
        t_single_read(12'h000);
        t_single_read(12'hFFF);
        t_stream();
        t_write_poll();
        t_mismatch();
        t_strap();
        t_abort();
        chk("R6 SDA changed while SCL high", oe_hi_scl, 0);
        chk("R5 conversion request while SCL high", conv_hi_scl, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule